// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst. A mode-load strobe stores the burst configuration from a 4-bit opcode field: a length code and an order bit. A start strobe carries the first column of a read or write. From the following cycle the block presents one column address per clock until the burst is complete, a stop strobe arrives, or a new start replaces it.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The order within the block is either sequential or interleaved. Full-page mode walks the whole column field and wraps at the page edge until it is stopped. A width select chooses a 9-bit column (byte-wide organisation) or an 8-bit column (halfword-wide organisation). The block moves no data and knows nothing of banks, rows or read latency.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `colValid` and `lastBeat` are 0 and `colAddr` is 0. The stored configuration is a single-beat sequential burst.
- R2: A `modeLoad` strobe stores `modeOp`. Bits 2:0 give the length: 000 one beat, 001 two, 010 four, 011 eight, 111 full page; the codes 100, 101 and 110 give one beat. Bit 3 selects interleaved order when 1. A new configuration applies only to starts in later cycles and does not change a burst in progress.
- R3: A `start` sampled at a clock edge makes `colValid` 1 from that edge. The first address is `startCol`, masked to the selected column width.
- R4: In sequential order the low log2(length) bits of the address count up from those of the start column and wrap. The upper bits stay those of the start column.
- R5: In interleaved order the low log2(length) bits of beat k equal the start column's low bits XOR k. The upper bits stay those of the start column.
- R6: In full-page mode the whole column increments by one each cycle, modulo 512 in 9-bit width or 256 in 8-bit width. The order bit is ignored and `lastBeat` stays 0.
- R7: In a fixed-length burst `lastBeat` is 1 exactly on the final beat. `colValid` falls in the next cycle unless a start arrives.
- R8: A `stop` sampled without `start` ends the burst, and `colValid` is 0 from that edge. A `start` together with `stop` starts a new burst.
- R9: A `start` in any cycle, including during a burst and on consecutive cycles, restarts the sequence from its own column and length.
- R10: With `wideCol` 0 at the start, bit 8 of every address of that burst is 0.
- R11: While `colValid` is 0, `colAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeLoad | input | 1 | Store `modeOp` as the burst configuration |
| modeOp | input | 4 | Opcode field: length code in 2:0, order in 3 |
| start | input | 1 | Begin a burst at `startCol` |
| startCol | input | 9 | First column of the burst |
| stop | input | 1 | End the burst in progress |
| wideCol | input | 1 | 1: 9-bit column, 0: 8-bit column |
| colAddr | output | 9 | Current column address |
| colValid | output | 1 | A burst beat is presented |
| lastBeat | output | 1 | Final beat of a fixed-length burst |

## Verification
Several rules are checked on every cycle by the assertions. An idle output is zero. A start yields a valid first beat equal to the masked start column. A stop, or a last beat without a new start, clears the valid flag. A last beat is always a valid beat, and an 8-bit burst never raises column bit 8. The address orders themselves can only be shown by the bench's scenarios: sequential and interleaved wrap, full-page wrap at both page sizes, and reserved length codes. So can the timing of a configuration change during a burst and restarts on consecutive cycles.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  // Configuration held after a mode load
  typedef struct packed {
    logic [1:0] lenLog2;
    logic       fullPage;
    logic       interleave;
  } modeCfg_t;

  // Configuration frozen for the burst in progress
  typedef struct packed {
    modeCfg_t mode;
    logic     wide;
  } burstCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } bcgStrobe_t;

  function automatic modeCfg_t decodeOp(input logic [3:0] op);
    modeCfg_t cfg;
    cfg.interleave = op[3];
    cfg.fullPage   = 1'b0;
    case (op[2:0])
      3'b000:  cfg.lenLog2 = 2'd0;
      3'b001:  cfg.lenLog2 = 2'd1;
      3'b010:  cfg.lenLog2 = 2'd2;
      3'b011:  cfg.lenLog2 = 2'd3;
      3'b111: begin
        cfg.lenLog2  = 2'd0;
        cfg.fullPage = 1'b1;
      end
      default: cfg.lenLog2 = 2'd0;
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int REM_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeLoad,
  input  logic [OP_W-1:0] modeOp,
  input  logic            start,
  input  logic            stop,
  input  logic            wideCol,
  output bcgStrobe_t      strobe,
  output burstCfg_t       activeCfg,
  output logic            busy,
  output logic            lastBeat
);

  modeCfg_t          modeCfg;
  logic [REM_W-1:0]  remain;
  logic [REM_W-1:0]  startRemain;

  // Beats left after the first one, for a fixed-length burst
  assign startRemain = modeCfg.fullPage ? '0
                     : REM_W'(({{REM_W{1'b0}}, 1'b1} << modeCfg.lenLog2) - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCfg <= '0;
    end else if (modeLoad) begin
      modeCfg <= decodeOp(modeOp[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remain    <= '0;
      activeCfg <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      remain    <= startRemain;
      activeCfg <= '{mode: modeCfg, wide: wideCol};
    end else if (stop) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (!activeCfg.mode.fullPage && remain == '0) begin
        busy <= 1'b0;
      end else if (!activeCfg.mode.fullPage) begin
        remain <= remain - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load = start;
    strobe.step = busy && !start && !stop;
    lastBeat    = busy && !activeCfg.mode.fullPage && (remain == '0);
  end

endmodule

// File: rtl/bcg_dpath.sv
module bcg_dpath
  import bcg_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcgStrobe_t       strobe,
  input  burstCfg_t        cfg,
  input  logic [COL_W-1:0] startCol,
  input  logic             colValid,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] NARROW_MASK = COL_W'((1 << NARROW_W) - 1);
  localparam logic [COL_W-1:0] WIDE_MASK   = '1;

  logic [COL_W-1:0] base;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] colMask;
  logic [COL_W-1:0] lowMask;
  logic [COL_W-1:0] lowPart;
  logic [COL_W-1:0] nextAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base <= '0;
      idx  <= '0;
    end else if (strobe.load) begin
      base <= startCol;
      idx  <= '0;
    end else if (strobe.step) begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    colMask = cfg.wide ? WIDE_MASK : NARROW_MASK;
    if (cfg.mode.fullPage) begin
      lowMask = colMask;
    end else begin
      lowMask = ({{(COL_W-1){1'b0}}, 1'b1} << cfg.mode.lenLog2) - 1'b1;
    end
    if (cfg.mode.interleave && !cfg.mode.fullPage) begin
      lowPart = base ^ idx;
    end else begin
      lowPart = base + idx;
    end
    nextAddr = ((base & ~lowMask) | (lowPart & lowMask)) & colMask;
    colAddr  = colValid ? nextAddr : '0;
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int NARROW_W = 8,
  parameter int OP_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [OP_W-1:0]  modeOp,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic             stop,
  input  logic             wideCol,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat
);

  bcgStrobe_t strobe;
  burstCfg_t  activeCfg;

  bcg_ctrl #(.OP_W(OP_W), .REM_W(3)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeLoad  (modeLoad),
    .modeOp    (modeOp),
    .start     (start),
    .stop      (stop),
    .wideCol   (wideCol),
    .strobe    (strobe),
    .activeCfg (activeCfg),
    .busy      (colValid),
    .lastBeat  (lastBeat)
  );

  bcg_dpath #(.COL_W(COL_W), .NARROW_W(NARROW_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfg      (activeCfg),
    .startCol (startCol),
    .colValid (colValid),
    .colAddr  (colAddr)
  );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W    = 9,
  parameter int NARROW_W = 8,
  parameter int OP_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeLoad,
  input logic [OP_W-1:0]  modeOp,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic             stop,
  input logic             wideCol,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             lastBeat
);

  localparam logic [COL_W-1:0] NARROW_MASK = COL_W'((1 << NARROW_W) - 1);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> colAddr == '0);

  assert_start_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> colValid);

  assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> colAddr == ($past(wideCol) ? $past(startCol) : ($past(startCol) & NARROW_MASK)));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !start) |=> !colValid);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !start) |=> !colValid);

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  assert_narrow_bit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !wideCol) |=> !colAddr[COL_W-1]);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .NARROW_W(NARROW_W), .OP_W(OP_W)) chk_i (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

  typedef struct packed {
    logic [3:0]       op;
    logic             wide;
    logic [8:0]       col;
    logic [3:0]       beats;
    logic [0:7][8:0]  exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{4'b0000, 1'b1, 9'h1A5, 4'd1, '{9'h1A5, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b0001, 1'b1, 9'h0F3, 4'd2, '{9'h0F3, 9'h0F2, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b0010, 1'b1, 9'h0F6, 4'd4, '{9'h0F6, 9'h0F7, 9'h0F4, 9'h0F5, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b1010, 1'b1, 9'h0F5, 4'd4, '{9'h0F5, 9'h0F4, 9'h0F7, 9'h0F6, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b0011, 1'b1, 9'h12D, 4'd8, '{9'h12D, 9'h12E, 9'h12F, 9'h128, 9'h129, 9'h12A, 9'h12B, 9'h12C}},
    '{4'b1011, 1'b1, 9'h12D, 4'd8, '{9'h12D, 9'h12C, 9'h12F, 9'h12E, 9'h129, 9'h128, 9'h12B, 9'h12A}},
    '{4'b0111, 1'b1, 9'h1FD, 4'd6, '{9'h1FD, 9'h1FE, 9'h1FF, 9'h000, 9'h001, 9'h002, 9'h0, 9'h0}},
    '{4'b0111, 1'b0, 9'h0FE, 4'd4, '{9'h0FE, 9'h0FF, 9'h000, 9'h001, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b0010, 1'b0, 9'h1F7, 4'd4, '{9'h0F7, 9'h0F4, 9'h0F5, 9'h0F6, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b0100, 1'b1, 9'h033, 4'd1, '{9'h033, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
    '{4'b1111, 1'b1, 9'h010, 4'd3, '{9'h010, 9'h011, 9'h012, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}
  };

  function automatic string reqOf(input int i);
    case (i)
      0:       return "R3";
      1, 2, 4: return "R4";
      3, 5:    return "R5";
      6, 7, 10: return "R6";
      8:       return "R10";
      default: return "R2";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeLoad = 1'b0;
  logic [3:0] modeOp = '0;
  logic       start = 1'b0;
  logic [8:0] startCol = '0;
  logic       stop = 1'b0;
  logic       wideCol = 1'b1;
  logic [8:0] colAddr;
  logic       colValid;
  logic       lastBeat;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .modeLoad (modeLoad),
    .modeOp   (modeOp),
    .start    (start),
    .startCol (startCol),
    .stop     (stop),
    .wideCol  (wideCol),
    .colAddr  (colAddr),
    .colValid (colValid),
    .lastBeat (lastBeat)
  );

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic loadMode(input logic [3:0] op);
    @(negedge clk);
    modeLoad = 1'b1;
    modeOp   = op;
    @(negedge clk);
    modeLoad = 1'b0;
  endtask

  // Drives start for one edge; returns at the negedge showing beat 0
  task automatic doStart(input logic [8:0] col, input logic wide);
    start    = 1'b1;
    startCol = col;
    wideCol  = wide;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat(input string req, input logic [8:0] addr, input logic last);
    chk(req, "colValid", {8'b0, colValid}, 9'd1);
    chk(req, "colAddr", colAddr, addr);
    chk(req, "lastBeat", {8'b0, lastBeat}, {8'b0, last});
  endtask

  task automatic idle(input string req);
    chk(req, "idle colValid", {8'b0, colValid}, 9'd0);
    chk(req, "idle colAddr", colAddr, 9'd0);
    chk(req, "idle lastBeat", {8'b0, lastBeat}, 9'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle("R1");
    rstN = 1'b1;
    @(negedge clk);
    idle("R1");
    // Reset configuration: one sequential beat
    doStart(9'h0C9, 1'b1);
    beat("R1", 9'h0C9, 1'b1);
    @(negedge clk);
    idle("R7");

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      bit full;
      full = (VECS[i].op[2:0] == 3'b111);
      loadMode(VECS[i].op);
      doStart(VECS[i].col, VECS[i].wide);
      for (int k = 0; k < int'(VECS[i].beats); k++) begin
        beat(reqOf(i), VECS[i].exp[k], !full && (k == int'(VECS[i].beats) - 1));
        if (full && k == int'(VECS[i].beats) - 1) stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
      end
      idle(full ? "R8" : "R7");
    end

    // R8: stop in the middle of an eight-beat burst
    loadMode(4'b0011);
    doStart(9'h040, 1'b1);
    beat("R8", 9'h040, 1'b0);
    @(negedge clk);
    beat("R8", 9'h041, 1'b0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    idle("R8");

    // R8: start and stop together start a burst
    stop = 1'b1;
    doStart(9'h050, 1'b1);
    stop = 1'b0;
    beat("R8", 9'h050, 1'b0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    idle("R8");

    // R9: restart during a burst, then on the very next cycle
    doStart(9'h060, 1'b1);
    beat("R9", 9'h060, 1'b0);
    @(negedge clk);
    beat("R9", 9'h061, 1'b0);
    doStart(9'h0A3, 1'b1);
    beat("R9", 9'h0A3, 1'b0);
    doStart(9'h0B0, 1'b1);
    beat("R9", 9'h0B0, 1'b0);
    @(negedge clk);
    beat("R9", 9'h0B1, 1'b0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    idle("R9");

    // R2: a mode load during a burst leaves that burst alone
    loadMode(4'b0010);
    doStart(9'h020, 1'b1);
    beat("R2", 9'h020, 1'b0);
    modeLoad = 1'b1;
    modeOp   = 4'b0000;
    @(negedge clk);
    modeLoad = 1'b0;
    beat("R2", 9'h021, 1'b0);
    @(negedge clk);
    beat("R2", 9'h022, 1'b0);
    @(negedge clk);
    beat("R2", 9'h023, 1'b1);
    @(negedge clk);
    idle("R2");
    doStart(9'h077, 1'b1);
    beat("R2", 9'h077, 1'b1);
    @(negedge clk);
    idle("R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule